// File: doc/BRIEF.md
# Converter Serial Port with Power-Mode Control

This block is the digital side of a four-channel, 12-bit sampling converter's serial port. A host frames each transfer by pulling an active-low select low and toggling a serial clock. While the host clocks, the block shifts a control word in and a 16-bit result frame out. The frame carries two zero bits, a 2-bit tag naming the converted channel, and the 12-bit result, which arrives on a parallel input because the analog side is modelled outside. A small control register holds the channel address and a 2-bit power mode. A header field decides whether the incoming word is stored at all.

The power mode sets when the block sleeps and wakes. Normal mode stays awake. Full shutdown sleeps after a transfer and stays asleep until a transfer writes normal mode back. Auto shutdown sleeps after every valid transfer and wakes on the next select fall. A wake takes a parameterised number of system clocks. Any frame that starts before the wake has finished is flagged stale. A stale frame does not send the block back to sleep, so an auto-shutdown host alternates a throw-away frame with a valid one.

Serial clock, select and data input are assumed synchronous to the system clock and to hold each level for at least two system clocks. The block finds their edges by comparing each input with its value on the previous clock. Every output reacts on the first system clock edge that sees an input change.

Top module: `adcsp_ctrl`

## Requirements
- R1: After a select fall, `dout` presents a 16-bit frame MSB first: two zeros, the channel address held in the register at that select fall, then `conv_result` sampled at that select fall. Bit 0 appears after the select fall, and each following bit appears after a serial-clock falling edge.
- R2: `dout_oe` is high from a select fall until the 16th serial-clock falling edge or an earlier select rise, and low at all other times. `dout` is 0 whenever `dout_oe` is low.
- R3: `din` is sampled MSB first on serial-clock falling edges. The control word layout is: bit 11 write-enable, bits 10:9 channel address, bits 8:7 power mode, bits 6:0 ignored. The word is stored on the 12th falling edge, and only when bit 11 is 1. A frame that is cut short before its 12th edge stores nothing.
- R4: A word whose bit 11 is 0 leaves both the channel address and the power mode unchanged.
- R5: On a frame that starts while the block is awake, `track_en` falls at the select fall and rises at the 14th serial-clock falling edge.
- R6: Power mode 2'b11 (normal) and the reserved code 2'b00 both keep `pwr_ready` high after a frame ends.
- R7: Power mode 2'b10 (full shutdown) drops `pwr_ready` and `track_en` at the 16th edge of a non-stale frame. The block stays asleep, in hold, through later frames until one of them writes 2'b11. Waking then starts at that frame's select rise.
- R8: Power mode 2'b01 (auto shutdown) drops `pwr_ready` at the end of every non-stale frame. The next select fall starts a wake and raises `track_en`.
- R9: `pwr_ready` rises WAKE_CYCLES system clocks after the clock edge that registers the wake event. `frame_stale` is high for a frame that began while `pwr_ready` was low, and the end of a stale frame never starts a shutdown.
- R10: The register contents, including the channel address on `chan_sel`, are kept through both shutdown modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Active-low transfer select |
| din | input | 1 | Serial control-word input |
| conv_result | input | RESULT_BITS | Parallel conversion result |
| dout | output | 1 | Serial frame output |
| dout_oe | output | 1 | Output enable for `dout` |
| track_en | output | 1 | 1 = track, 0 = hold |
| pwr_ready | output | 1 | Block fully powered |
| frame_stale | output | 1 | Current or last frame began before power-up |
| chan_sel | output | TAG_BITS | Stored channel address, drives the input mux |

## Verification
A corrupted bit counter shows up at the ports within one frame: `dout_oe` ends on the wrong edge, the tag or result bits shift, or `track_en` rises on the wrong edge. A wrong register commit is visible on `chan_sel` and in the next frame's tag at the following select fall. A power state that is lost or stuck shows on `pwr_ready` at the end of the frame. It also shows at the start of the next frame, through `frame_stale`, or WAKE_CYCLES clocks after a wake event.

// File: rtl/adcsp_pkg.sv
// Shared types for the converter serial port.
// Assumes a 2-bit channel tag and a 2-bit power-mode field.
package adcsp_pkg;
    localparam int TAG_BITS  = 2;
    localparam int LEAD_BITS = 2;

    typedef enum logic [1:0] {
        PM_RSVD   = 2'b00,
        PM_AUTO   = 2'b01,
        PM_FULL   = 2'b10,
        PM_NORMAL = 2'b11
    } pm_e;

    typedef enum logic [1:0] {
        PS_ON   = 2'b00,
        PS_OFF  = 2'b01,
        PS_WAKE = 2'b10
    } pstate_e;

    // Leading field of the control word, MSB first on the wire.
    typedef struct packed {
        logic                wr;
        logic [TAG_BITS-1:0] chan;
        pm_e                 pm;
    } ctrl_hdr_s;

    // Register contents kept across frames.
    typedef struct packed {
        logic [TAG_BITS-1:0] chan;
        pm_e                 pm;
    } ctrl_reg_s;

    localparam int HDR_BITS = $bits(ctrl_hdr_s);
endpackage

// File: rtl/adcsp_frame.sv
// Serial framing unit. Finds select and serial-clock edges by sampling them on clk.
// Shifts the control-word header in and the result frame out, and reports the
// 12th, 14th and last falling edge as single-cycle pulses.
// Assumes the serial inputs are synchronous to clk and hold each level for at least 2 clks.
module adcsp_frame
    import adcsp_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int CTRL_BITS  = 12,
    parameter int TRACK_EDGE = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  cs_n,
    input  logic                  din,
    input  logic [FRAME_BITS-1:0] tx_word,
    output logic                  dout,
    output logic                  dout_oe,
    output logic                  cs_fall_o,
    output logic                  cs_rise_o,
    output logic                  word_valid_o,
    output logic [HDR_BITS-1:0]   ctrl_hdr_o,
    output logic                  track_edge_o,
    output logic                  frame_end_o
);
    localparam int CW = $clog2(FRAME_BITS + 1);

    logic                  cs_q, sclk_q, active, oe_q;
    logic [CW-1:0]         cnt, cnt_nx;
    logic [HDR_BITS-1:0]   in_sh;
    logic [FRAME_BITS-1:0] out_sh;
    logic                  sclk_fall, bit_edge;

    // Edge decode and falling-edge event pulses.
    always_comb begin
        sclk_fall    = sclk_q & ~sclk;
        cs_fall_o    = cs_q & ~cs_n;
        cs_rise_o    = ~cs_q & cs_n;
        bit_edge     = active & ~cs_n & sclk_fall;
        cnt_nx       = cnt + CW'(1);
        word_valid_o = bit_edge && (cnt_nx == CW'(CTRL_BITS));
        track_edge_o = bit_edge && (cnt_nx == CW'(TRACK_EDGE));
        frame_end_o  = bit_edge && (cnt_nx == CW'(FRAME_BITS));
        ctrl_hdr_o   = in_sh;
        dout         = oe_q & out_sh[FRAME_BITS-1];
        dout_oe      = oe_q;
    end

    // Frame sequencing: load at select fall, shift per falling edge, stop at end or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b1;
            active <= 1'b0;
            oe_q   <= 1'b0;
            cnt    <= '0;
            in_sh  <= '0;
            out_sh <= '0;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
            if (cs_fall_o) begin
                active <= 1'b1;
                oe_q   <= 1'b1;
                cnt    <= '0;
                out_sh <= tx_word;
            end else if (cs_rise_o) begin
                active <= 1'b0;
                oe_q   <= 1'b0;
            end else if (bit_edge) begin
                cnt    <= cnt_nx;
                out_sh <= out_sh << 1;
                if (cnt < CW'(HDR_BITS))
                    in_sh <= {in_sh[HDR_BITS-2:0], din};
                if (frame_end_o) begin
                    active <= 1'b0;
                    oe_q   <= 1'b0;
                end
            end
        end
    end

    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(FRAME_BITS));
    assert_oe_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && cs_q) |-> !dout_oe);
    assert_oe_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> $past(cs_fall_o));
endmodule

// File: rtl/adcsp_power.sv
// Power-mode sequencer. Tracks awake, asleep and waking states and the track/hold
// output, and counts the wake delay in clk cycles.
// Assumes the event pulses from the framing unit last one cycle and never coincide.
module adcsp_power
    import adcsp_pkg::*;
#(
    parameter int WAKE_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  pm_e  pm,
    input  logic cs_fall_i,
    input  logic cs_rise_i,
    input  logic track_edge_i,
    input  logic frame_end_i,
    output logic track_en,
    output logic pwr_ready,
    output logic frame_stale
);
    localparam int WW = $clog2(WAKE_CYCLES + 1);

    pstate_e       state;
    logic [WW-1:0] wake_cnt;
    logic          track_q, stale_q;

    // Output view of the power state.
    always_comb begin
        pwr_ready   = (state == PS_ON);
        track_en    = track_q;
        frame_stale = stale_q;
    end

    // Power state, wake counter and track/hold control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PS_ON;
            wake_cnt <= '0;
            track_q  <= 1'b1;
            stale_q  <= 1'b0;
        end else begin
            if (state == PS_WAKE) begin
                wake_cnt <= wake_cnt + WW'(1);
                if (wake_cnt == WW'(WAKE_CYCLES - 1))
                    state <= PS_ON;
            end
            if (cs_fall_i) begin
                stale_q <= (state != PS_ON);
                track_q <= 1'b0;
                if (state == PS_OFF && pm == PM_AUTO) begin
                    state    <= PS_WAKE;
                    wake_cnt <= '0;
                    track_q  <= 1'b1;
                end
            end
            if (cs_rise_i && state == PS_OFF && pm == PM_NORMAL) begin
                state    <= PS_WAKE;
                wake_cnt <= '0;
            end
            if (track_edge_i && !(state == PS_OFF && pm != PM_NORMAL))
                track_q <= 1'b1;
            if (frame_end_i && !stale_q && (pm == PM_FULL || pm == PM_AUTO)) begin
                state   <= PS_OFF;
                track_q <= 1'b0;
            end
        end
    end

    assert_ready_from_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_ready) |-> $past(state == PS_WAKE));
    assert_sleep_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_OFF && $past(state) != PS_OFF) |-> $past(frame_end_i));
    assert_wake_on_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_WAKE && $past(state) == PS_OFF) |-> $past(cs_fall_i || cs_rise_i));
    assert_hold_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(track_en) |-> $past(cs_fall_i || frame_end_i));
endmodule

// File: rtl/adcsp_ctrl.sv
// Top of the converter serial port. Holds the control register, builds the
// outgoing frame and connects the framing unit to the power sequencer.
// Assumes the result input is stable around each select fall.
module adcsp_ctrl
    import adcsp_pkg::*;
#(
    parameter int RESULT_BITS = 12,
    parameter int CTRL_BITS   = 12,
    parameter int TRACK_EDGE  = 14,
    parameter int WAKE_CYCLES = 50
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sclk,
    input  logic                   cs_n,
    input  logic                   din,
    input  logic [RESULT_BITS-1:0] conv_result,
    output logic                   dout,
    output logic                   dout_oe,
    output logic                   track_en,
    output logic                   pwr_ready,
    output logic                   frame_stale,
    output logic [TAG_BITS-1:0]    chan_sel
);
    localparam int FRAME_BITS = LEAD_BITS + TAG_BITS + RESULT_BITS;

    ctrl_reg_s             ctrl_q;
    ctrl_hdr_s             hdr;
    logic [HDR_BITS-1:0]   hdr_bits;
    logic [FRAME_BITS-1:0] tx_word;
    logic cs_fall, cs_rise, word_valid, track_edge, frame_end;

    // Frame content and header decode.
    always_comb begin
        tx_word  = {LEAD_BITS'(0), ctrl_q.chan, conv_result};
        hdr      = ctrl_hdr_s'(hdr_bits);
        chan_sel = ctrl_q.chan;
    end

    // Control register: commits on the 12th edge only when the write bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '{chan: '0, pm: PM_NORMAL};
        else if (word_valid && hdr.wr)
            ctrl_q <= '{chan: hdr.chan, pm: hdr.pm};
    end

    adcsp_frame #(
        .FRAME_BITS(FRAME_BITS),
        .CTRL_BITS (CTRL_BITS),
        .TRACK_EDGE(TRACK_EDGE)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk        (sclk),
        .cs_n        (cs_n),
        .din         (din),
        .tx_word     (tx_word),
        .dout        (dout),
        .dout_oe     (dout_oe),
        .cs_fall_o   (cs_fall),
        .cs_rise_o   (cs_rise),
        .word_valid_o(word_valid),
        .ctrl_hdr_o  (hdr_bits),
        .track_edge_o(track_edge),
        .frame_end_o (frame_end)
    );

    adcsp_power #(
        .WAKE_CYCLES(WAKE_CYCLES)
    ) u_power (
        .clk         (clk),
        .rst_n       (rst_n),
        .pm          (ctrl_q.pm),
        .cs_fall_i   (cs_fall),
        .cs_rise_i   (cs_rise),
        .track_edge_i(track_edge),
        .frame_end_i (frame_end),
        .track_en    (track_en),
        .pwr_ready   (pwr_ready),
        .frame_stale (frame_stale)
    );

    assert_write_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q) |-> $past(word_valid && hdr.wr));
endmodule

// File: tb/adcsp_ctrl_tb.sv
// Directed bench for adcsp_ctrl: one task per scenario, each checking its results.
module adcsp_ctrl_tb;
    localparam int W = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        cs_n = 1'b1;
    logic        din = 1'b0;
    logic [11:0] conv_result = '0;
    logic        dout, dout_oe, track_en, pwr_ready, frame_stale;
    logic [1:0]  chan_sel;

    int checks = 0;
    int errors = 0;

    logic [15:0] got;
    logic trk_fall, trk13, trk14, stale_s, oe_end, oe_idle, oe_mid, dout_idle;

    always #10 clk = ~clk;

    adcsp_ctrl #(.WAKE_CYCLES(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
        .conv_result(conv_result), .dout(dout), .dout_oe(dout_oe),
        .track_en(track_en), .pwr_ready(pwr_ready), .frame_stale(frame_stale),
        .chan_sel(chan_sel)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] mk(input logic wr, input logic [1:0] ch, input logic [1:0] pm);
        return {wr, ch, pm, 7'h00};
    endfunction

    // One transfer of n falling edges; select is released afterwards.
    task automatic xfer(input logic [11:0] word, input int n);
        @(negedge clk) cs_n = 1'b0;
        repeat (3) @(negedge clk);
        trk_fall = track_en;
        stale_s  = frame_stale;
        oe_mid   = dout_oe;
        got = '0;
        trk13 = 1'b0;
        trk14 = 1'b0;
        for (int i = 0; i < n; i++) begin
            got[15-i] = dout;
            din  = (i < 12) ? word[11-i] : 1'b0;
            sclk = 1'b0;
            repeat (3) @(negedge clk);
            if (i == 12) trk13 = track_en;
            if (i == 13) trk14 = track_en;
            sclk = 1'b1;
            repeat (3) @(negedge clk);
        end
        oe_end = dout_oe;
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        oe_idle   = dout_oe;
        dout_idle = dout;
    endtask

    task automatic t_reset();
        check("R2 reset oe", dout_oe, 0);
        check("R5 reset track", track_en, 1);
        check("R6 reset ready", pwr_ready, 1);
        check("R3 reset chan", chan_sel, 0);
    endtask

    task automatic t_frame();
        conv_result = 12'hA5C;
        xfer(mk(1'b1, 2'd2, 2'b11), 16);
        check("R1 frame tag0", got, 16'h0A5C);
        check("R2 oe during", oe_mid, 1);
        check("R2 oe after 16th", oe_end, 0);
        check("R2 oe idle", oe_idle, 0);
        check("R2 dout idle", dout_idle, 0);
        check("R5 hold at fall", trk_fall, 0);
        check("R5 hold at 13", trk13, 0);
        check("R5 track at 14", trk14, 1);
        check("R3 chan written", chan_sel, 2);
        conv_result = 12'h3C1;
        xfer(mk(1'b0, 2'd1, 2'b10), 16);
        check("R1 frame tag2", got, 16'h23C1);
        check("R4 chan kept", chan_sel, 2);
        check("R4 mode kept", pwr_ready, 1);
    endtask

    task automatic t_abort();
        xfer(mk(1'b1, 2'd3, 2'b01), 8);
        check("R2 oe after abort", oe_idle, 0);
        check("R3 short frame chan", chan_sel, 2);
        xfer(mk(1'b0, 2'd0, 2'b00), 16);
        check("R3 short frame mode", pwr_ready, 1);
    endtask

    task automatic t_reserved();
        xfer(mk(1'b1, 2'd2, 2'b00), 16);
        check("R6 reserved awake", pwr_ready, 1);
        xfer(mk(1'b1, 2'd2, 2'b11), 16);
        check("R6 normal awake", pwr_ready, 1);
    endtask

    task automatic t_full();
        xfer(mk(1'b1, 2'd1, 2'b10), 16);
        check("R7 full asleep", pwr_ready, 0);
        check("R7 full hold", track_en, 0);
        xfer(mk(1'b0, 2'd0, 2'b00), 16);
        check("R9 stale while off", stale_s, 1);
        check("R7 hold at 14", trk14, 0);
        check("R7 still asleep", pwr_ready, 0);
        check("R10 chan kept full", chan_sel, 1);
        xfer(mk(1'b1, 2'd1, 2'b11), 16);
        check("R7 wake track 14", trk14, 1);
        repeat (W - 3) @(negedge clk);
        check("R9 not yet ready", pwr_ready, 0);
        @(negedge clk);
        check("R9 ready on time", pwr_ready, 1);
        check("R10 chan after wake", chan_sel, 1);
    endtask

    task automatic t_auto();
        xfer(mk(1'b1, 2'd3, 2'b01), 16);
        check("R8 auto asleep", pwr_ready, 0);
        xfer(mk(1'b0, 2'd0, 2'b00), 16);
        check("R8 wake to track", trk_fall, 1);
        check("R9 dummy stale", stale_s, 1);
        check("R9 no sleep after stale", pwr_ready, 1);
        conv_result = 12'h7E2;
        xfer(mk(1'b0, 2'd0, 2'b00), 16);
        check("R9 valid frame", stale_s, 0);
        check("R1 frame tag3", got, 16'h37E2);
        check("R8 auto sleeps again", pwr_ready, 0);
        check("R10 chan kept auto", chan_sel, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_frame();
        t_abort();
        t_reserved();
        t_full();
        t_auto();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule